// File: doc/BRIEF.md
# Packed BCD chain adder

This unit adds two bytes that each hold two packed decimal digits, plus an incoming extend bit. It returns a decimal result byte and updates a five-bit condition-code register. The register sits inside the unit. It is meant for long decimal numbers that are processed one byte at a time, least significant byte first. The decimal carry out of each byte is copied into the extend flag, and the next byte picks it up as its carry in.

Before a chain starts, the caller writes the flags directly with the load strobe, normally with extend clear and zero set. After that, every start strobe runs one byte addition. The zero flag can only be cleared by an addition, never set. If it is still set after the last byte, the whole multi-byte decimal result was zero.

The data interface is a plain strobe pair with no back-pressure. The unit accepts a start in every cycle, including back-to-back cycles. It answers each accepted start with a one-cycle done pulse in the following cycle, and the result is valid in that cycle. Flag bit positions are: extend bit 4, negative bit 3, zero bit 2, overflow bit 1, carry bit 0.

Top module: `bcd_chain_adder`

## Requirements
- R1: On a clock edge where start is high and flag_load is low, result takes the BCD encoding of (src + dst + extend flag) mod 100, where src and dst are read as two-digit decimals (high nibble tens, low nibble units). The value is visible after that edge.
- R2: When both operands hold valid BCD digits (each nibble 0 to 9), each nibble of the result is in the range 0 to 9.
- R3: After an addition, carry flag (bit 0) is 1 exactly when src + dst + extend is 100 or more.
- R4: After an addition, extend flag (bit 4) equals the carry flag (bit 0).
- R5: An addition clears the zero flag (bit 2) when its result byte is non-zero and leaves it unchanged when the result is zero. An addition never sets it.
- R6: An addition leaves the negative (bit 3) and overflow (bit 1) flags unchanged.
- R7: A clock edge with flag_load high writes flag_in into the whole flag register.
- R8: done is high for exactly the one cycle after each accepted start. Starts in consecutive cycles each produce a done pulse, and each uses the extend flag left by the previous byte.
- R9: When flag_load and start are high on the same edge, the load wins. The addition is dropped, result keeps its value, and no done pulse follows.
- R10: While rst_n is low, result, flags and done are all zero.
- R11: result holds its value in cycles with no accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_load | input | 1 | Write flag_in into the flag register |
| flag_in | input | 5 | Flag value to load (X,N,Z,V,C from bit 4 down) |
| start | input | 1 | Run one byte addition |
| src_byte | input | 8 | Source operand, two packed BCD digits |
| dst_byte | input | 8 | Destination operand, two packed BCD digits |
| result | output | 8 | Registered BCD sum byte |
| flags | output | 5 | Flag register (X,N,Z,V,C from bit 4 down) |
| done | output | 1 | One-cycle pulse after an accepted start |

## Verification
The assertions check these rules on every cycle:
- extend tracks carry after each addition;
- zero never rises except through a load;
- a non-zero result never leaves zero set;
- negative and overflow hold still unless loaded;
- done pulses only after an accepted start;
- a load always lands exactly;
- result digits stay decimal for decimal operands.

Only the bench scenarios can show that the sums themselves are right across the digit-correction boundaries. The same goes for whether the decimal carry ripples correctly through a multi-byte chain, whether zero stays sticky over a whole chain, and how a load and a start in the same cycle resolve.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int CCR_W  = 5;
  localparam int FLAG_X = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
  localparam int NIBBLE_W = 4;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout
);
  localparam int RAW_W = DW + 1;
  localparam logic [RAW_W-1:0] LIMIT = RAW_W'(9);
  localparam logic [RAW_W-1:0] CORR  = RAW_W'(6);

  logic [RAW_W-1:0] raw;
  logic [RAW_W-1:0] adj;

  // A raw digit sum above nine (including a binary carry) needs a +6 fix-up
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + RAW_W'(cin);
    cout = (raw > LIMIT);
    adj  = cout ? (raw + CORR) : raw;
    sum  = adj[DW-1:0];
  end
endmodule

// File: rtl/bcd_byte_add.sv
module bcd_byte_add #(
  parameter int NDIGITS = 2,
  parameter int DW      = 4
) (
  input  logic [NDIGITS*DW-1:0] a,
  input  logic [NDIGITS*DW-1:0] b,
  input  logic                  cin,
  output logic [NDIGITS*DW-1:0] sum,
  output logic                  cout
);
  localparam int BW = NDIGITS * DW;
  localparam logic [DW-1:0] DIG_MAX = DW'(9);

  logic [NDIGITS:0] carry;
  assign carry[0] = cin;

  for (genvar g = 0; g < NDIGITS; g++) begin : g_digit
    bcd_digit_add #(.DW(DW)) u_dig (
      .a    (a[g*DW +: DW]),
      .b    (b[g*DW +: DW]),
      .cin  (carry[g]),
      .sum  (sum[g*DW +: DW]),
      .cout (carry[g+1])
    );
  end

  assign cout = carry[NDIGITS];

  function automatic logic all_decimal(input logic [BW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NDIGITS; i++) begin
      if (v[i*DW +: DW] > DIG_MAX) ok = 1'b0;
    end
    return ok;
  endfunction

  // R2: decimal operands always give decimal result digits
  always_comb begin
    if (all_decimal(a) && all_decimal(b)) begin
      a_r2_digit_range: assert (all_decimal(sum));
    end
  end
endmodule

// File: rtl/bcd_flag_reg.sv
module bcd_flag_reg
  import bcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CCR_W-1:0] load_val,
  input  logic             fire,
  input  logic             carry,
  input  logic             nonzero,
  output logic [CCR_W-1:0] ccr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr_q <= '0;
    end else if (load) begin
      ccr_q <= load_val;
    end else if (fire) begin
      ccr_q[FLAG_C] <= carry;
      ccr_q[FLAG_X] <= carry;
      if (nonzero) ccr_q[FLAG_Z] <= 1'b0;
    end
  end

  // R4: extend mirrors carry after an addition
  a_r4_x_tracks_c: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load) |=> (ccr_q[FLAG_X] == ccr_q[FLAG_C]));

  // R5: zero can only rise through a load
  a_r5_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ccr_q[FLAG_Z]) |-> $past(load));

  // R6: negative and overflow untouched by additions
  a_r6_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> ($stable(ccr_q[FLAG_N]) && $stable(ccr_q[FLAG_V])));
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
  import bcd_pkg::*;
#(
  parameter int NDIGITS = 2,
  parameter int DW      = NIBBLE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flag_load,
  input  logic [CCR_W-1:0]      flag_in,
  input  logic                  start,
  input  logic [NDIGITS*DW-1:0] src_byte,
  input  logic [NDIGITS*DW-1:0] dst_byte,
  output logic [NDIGITS*DW-1:0] result,
  output logic [CCR_W-1:0]      flags,
  output logic                  done
);
  localparam int BW = NDIGITS * DW;

  logic          fire;
  logic [BW-1:0] sum_c;
  logic          carry_c;
  logic [BW-1:0] result_q;
  logic          done_q;
  logic [CCR_W-1:0] ccr_q;

  // R9: a flag load in the same cycle drops the addition
  assign fire = start & ~flag_load;

  bcd_byte_add #(.NDIGITS(NDIGITS), .DW(DW)) u_add (
    .a    (src_byte),
    .b    (dst_byte),
    .cin  (ccr_q[FLAG_X]),
    .sum  (sum_c),
    .cout (carry_c)
  );

  bcd_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (flag_load),
    .load_val (flag_in),
    .fire     (fire),
    .carry    (carry_c),
    .nonzero  (|sum_c),
    .ccr_q    (ccr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) result_q <= sum_c;
    end
  end

  assign result = result_q;
  assign flags  = ccr_q;
  assign done   = done_q;

  // R8: done only follows an accepted start
  a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(start && !flag_load));

  // R5: a non-zero result never leaves zero set
  a_r5_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (result_q != '0)) |-> !ccr_q[FLAG_Z]);

  // R7: a load lands exactly
  a_r7_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (ccr_q == $past(flag_in)));

  // R11: result frozen without an accepted start
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(result_q));
endmodule

// File: tb/bcd_chain_adder_test.sv
module bcd_chain_adder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_load = 1'b0;
  logic [4:0] flag_in = '0;
  logic       start = 1'b0;
  logic [7:0] src_byte = '0;
  logic [7:0] dst_byte = '0;
  logic [7:0] result;
  logic [4:0] flags;
  logic       done;

  int applied = 0;
  int misses  = 0;

  always #2 clk = ~clk;

  bcd_chain_adder uut (
    .clk(clk), .rst_n(rst_n), .flag_load(flag_load), .flag_in(flag_in),
    .start(start), .src_byte(src_byte), .dst_byte(dst_byte),
    .result(result), .flags(flags), .done(done)
  );

  // {src, dst, x_in, expected result, expected carry}
  localparam logic [25:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    {8'h12, 8'h34, 1'b0, 8'h46, 1'b0},
    {8'h45, 8'h45, 1'b1, 8'h91, 1'b0},
    {8'h99, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'h99, 8'h99, 1'b1, 8'h99, 1'b1},
    {8'h09, 8'h01, 1'b0, 8'h10, 1'b0},
    {8'h58, 8'h47, 1'b0, 8'h05, 1'b1},
    {8'h50, 8'h50, 1'b0, 8'h00, 1'b1},
    {8'h19, 8'h19, 1'b0, 8'h38, 1'b0},
    {8'h08, 8'h08, 1'b1, 8'h17, 1'b0},
    {8'h37, 8'h62, 1'b1, 8'h00, 1'b1},
    {8'h00, 8'h00, 1'b1, 8'h01, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_flags(input logic [4:0] v);
    @(negedge clk);
    flag_load = 1'b1;
    flag_in   = v;
    @(negedge clk);
    flag_load = 1'b0;
  endtask

  task automatic do_op(input logic [7:0] s, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; src_byte = s; dst_byte = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  // At a negedge with start held high, check the previous byte and present the next
  task automatic chain_step(input logic [7:0] s, input logic [7:0] d,
                            input logic [7:0] er, input logic ec, input logic ez,
                            input logic more);
    @(negedge clk);
    chk("R8 chain done", {7'd0, done}, 8'd1);
    chk("R1 chain result", result, er);
    chk("R3 chain carry", {7'd0, flags[0]}, {7'd0, ec});
    chk("R4 chain extend", {7'd0, flags[4]}, {7'd0, ec});
    chk("R5 chain zero", {7'd0, flags[2]}, {7'd0, ez});
    src_byte = s; dst_byte = d; start = more;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    misses++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 result in reset", result, 8'h00);
    chk("R10 flags in reset", {3'd0, flags}, 8'h00);
    chk("R10 done in reset", {7'd0, done}, 8'd0);
    rst_n = 1'b1;

    // R7: direct flag write; N and V values are left alone (R6 covered by assertions)
    load_flags(5'b01011);
    chk("R7 flag load", {3'd0, flags}, 8'h0B);

    // Table walk: R1, R3, R4, R5, R8
    for (int i = 0; i < 12; i++) begin
      logic [7:0] vs, vd, vr;
      logic vx, vc;
      {vs, vd, vx, vr, vc} = VEC[i];
      load_flags({vx, 1'b1, 1'b1, 1'b0, 1'b0});
      do_op(vs, vd);
      chk("R1 sum", result, vr);
      chk("R3 carry", {7'd0, flags[0]}, {7'd0, vc});
      chk("R4 extend", {7'd0, flags[4]}, {7'd0, vc});
      chk("R5 zero", {7'd0, flags[2]}, {7'd0, (vr == 8'h00)});
      chk("R8 done", {7'd0, done}, 8'd1);
      chk("R2 low digit", {4'd0, result[3:0]} <= 8'd9 ? 8'd1 : 8'd0, 8'd1);
    end

    // R8 pulse width and R11 hold
    held = result;
    @(negedge clk);
    chk("R8 done falls", {7'd0, done}, 8'd0);
    chk("R11 result holds", result, held);

    // R9: load and start together
    @(negedge clk);
    flag_load = 1'b1; flag_in = 5'b10100;
    start = 1'b1; src_byte = 8'h11; dst_byte = 8'h11;
    @(negedge clk);
    flag_load = 1'b0; start = 1'b0;
    chk("R9 no done", {7'd0, done}, 8'd0);
    chk("R9 result kept", result, held);
    chk("R9 flags loaded", {3'd0, flags}, 8'h14);

    // Chain 1: 999999 + 000001 gives zero with carry; Z stays set
    load_flags(5'b00100);
    @(negedge clk);
    start = 1'b1; src_byte = 8'h99; dst_byte = 8'h01;
    chain_step(8'h99, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
    chain_step(8'h99, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
    chain_step(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);

    // Chain 2: one non-zero byte clears Z for good
    load_flags(5'b00100);
    @(negedge clk);
    start = 1'b1; src_byte = 8'h25; dst_byte = 8'h75;
    chain_step(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
    chain_step(8'h99, 8'h00, 8'h01, 1'b0, 1'b0, 1'b1);
    chain_step(8'h00, 8'h00, 8'h99, 1'b0, 1'b0, 1'b1);
    chain_step(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    @(negedge clk);
    chk("R8 chain done falls", {7'd0, done}, 8'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end
endmodule